// File: doc/BRIEF.md
# Disk Sector ID Search Controller

This block sequences the execution phase of a read command in a floppy-style disk controller. A start strobe captures the requested track, head, sector and size code, the last sector number of a track, a multi-track flag, a skip-deleted flag and a data-field timeout in byte times. The block then watches decoded address-field events, data-mark events and index pulses from an upstream data separator.

It compares every address field against the current target. Non-matching fields are passed over. A match is followed by a wait for the data mark. If no ID matches within two index pulses, or the data mark never arrives, or an address field carries a CRC error, the block ends the command. It records the cause in two status bytes that follow the usual controller result-byte layout.

After each sector has been transferred, the target sector number advances. At the end of the track the command either stops, or, in multi-track mode, continues on side 1 starting at sector 1. A host write to the command FIFO aborts the command at any point.

Top module: `sector_seek_ctl`

## Requirements
- R1: After reset, busy, done and data_start are 0 and both status bytes are 00h.
- R2: A start strobe while idle captures the command fields, raises busy and clears both status bytes. A start strobe while busy is ignored and the captured target is kept.
- R3: An address field matches only when its track, head, sector and size code all equal the current target. A non-matching field leaves the search running.
- R4: If a second index pulse arrives during a search with no match and no address field seen, the command ends with status1 bit 0 (missing address mark) set.
- R5: If the search times out after address fields were seen and the last field's track equals the requested track, status1 bit 2 (missing data) is set.
- R6: If the search times out and the last seen track differs from the requested one, status2 bit 4 (wrong track) is set. When that track is FFh, status2 bit 1 (bad track) is set instead.
- R7: An address field flagged with a CRC error during a search ends the command with status1 bit 5 set.
- R8: After a match, if gap_limit byte ticks pass with no data mark, the command ends with status1 bit 0 set. Fewer ticks do not end it.
- R9: A normal data mark, or a deleted mark with skip off, pulses data_start in the following cycle. A deleted mark with skip on gives no data_start and advances to the next sector's search.
- R10: When sec_done arrives below the end-of-track sector, the target sector increments and the search restarts. At the end-of-track sector in single-track mode, the command ends with both status bytes 00h.
- R11: In multi-track mode, end of track on side 0 continues on side 1 at sector 1 (hd_side=1). End of track on side 1 ends the command.
- R12: host_wr while busy ends the command on the next edge, with busy 0 and status bytes unchanged.
- R13: done is a single-cycle pulse marking each return to idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Command start strobe |
| req_track | input | 8 | Requested track number |
| req_head | input | 8 | Requested head number (bit 0 is the side) |
| req_sector | input | 8 | First sector to read |
| req_size | input | 8 | Requested bytes-per-sector code |
| eot_sector | input | 8 | Last sector number of a track |
| multi_trk | input | 1 | Continue to side 1 at end of track |
| skip_del | input | 1 | Skip sectors with a deleted data mark |
| gap_limit | input | 16 | Data-field timeout in byte ticks (at least 1) |
| byte_tick | input | 1 | One pulse per byte time |
| index_pulse | input | 1 | Index hole strobe |
| id_valid | input | 1 | Address field decoded this cycle |
| id_track | input | 8 | Track byte of the address field |
| id_head | input | 8 | Head byte of the address field |
| id_sector | input | 8 | Sector byte of the address field |
| id_size | input | 8 | Size code of the address field |
| id_crc_err | input | 1 | CRC error on this address field |
| dmark_valid | input | 1 | Data mark found this cycle |
| dmark_deleted | input | 1 | The data mark is a deleted mark |
| sec_done | input | 1 | Sector data transfer complete |
| host_wr | input | 1 | Host wrote the command FIFO (abort) |
| busy | output | 1 | Command executing |
| done | output | 1 | One-cycle pulse on entering the result phase |
| data_start | output | 1 | Sector found, data transfer starts |
| st1 | output | 8 | Status byte 1 |
| st2 | output | 8 | Status byte 2 |
| hd_side | output | 1 | Side currently searched |
| cur_sec | output | 8 | Sector number currently targeted |

## Verification
The hardest state to reach is the side-1 part of a multi-track command. It exists only after a full sector cycle on side 0 at the end-of-track sector: a match, a data mark and sec_done. The bench starts at the last sector of side 0, completes that cycle, and then checks hd_side, cur_sec and a second match on side 1. The timeout classifications need a particular last-seen address field before two index pulses arrive. They are reached by a table of single probe fields, each followed by a pair of index pulses.

// File: rtl/sss_pkg.sv
package sss_pkg;
  typedef enum logic [1:0] {
    S_IDLE    = 2'd0,
    S_SEARCH  = 2'd1,
    S_WAIT_DM = 2'd2,
    S_XFER    = 2'd3
  } sss_state_e;

  localparam int ST1_NOMARK = 0;
  localparam int ST1_NODATA = 2;
  localparam int ST1_CRC    = 5;
  localparam int ST2_BADTRK = 1;
  localparam int ST2_WRTRK  = 4;
endpackage

// File: rtl/sss_id_match.sv
module sss_id_match #(
  parameter int W = 8,
  parameter int NF = 4
) (
  input  logic [NF-1:0][W-1:0] got,
  input  logic [NF-1:0][W-1:0] want,
  output logic [NF-1:0]        eq,
  output logic                 hit
);
  for (genvar i = 0; i < NF; i++) begin : g_fld
    assign eq[i] = (got[i] == want[i]);
  end
  assign hit = &eq;
endmodule

// File: rtl/sss_index_watch.sv
module sss_index_watch #(
  parameter int NP = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic en,
  input  logic pulse,
  output logic expire
);
  localparam int CW = $clog2(NP + 1);
  localparam logic [CW-1:0] LAST = CW'(NP - 1);

  logic [CW-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (clr)
      cnt_d = '0;
    else if (en && pulse)
      cnt_d = (cnt_q == LAST) ? '0 : cnt_q + CW'(1);
  end

  assign expire = en && pulse && !clr && (cnt_q == LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  // R4: pulse count never reaches the limit without expiring
  a_r4_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q < CW'(NP));
endmodule

// File: rtl/sss_data_timer.sv
module sss_data_timer #(
  parameter int TW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          en,
  input  logic          tick,
  input  logic [TW-1:0] limit,
  output logic          expire
);
  logic [TW-1:0] cnt_q, cnt_d;
  logic [TW:0]   cnt_inc;

  assign cnt_inc = {1'b0, cnt_q} + (TW+1)'(1);
  assign expire  = en && tick && !clr && (cnt_inc >= {1'b0, limit});

  always_comb begin
    cnt_d = cnt_q;
    if (clr)
      cnt_d = '0;
    else if (en && tick && !expire)
      cnt_d = cnt_inc[TW-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  // R8: while waiting, the count stays below the limit
  a_r8_timer_bound: assert property (@(posedge clk) disable iff (!rst_n)
    (en && limit != '0) |-> (cnt_q < limit));
endmodule

// File: rtl/sector_seek_ctl.sv
module sector_seek_ctl #(
  parameter int W  = 8,
  parameter int TW = 16,
  parameter int NIDX = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [W-1:0]  req_track,
  input  logic [W-1:0]  req_head,
  input  logic [W-1:0]  req_sector,
  input  logic [W-1:0]  req_size,
  input  logic [W-1:0]  eot_sector,
  input  logic          multi_trk,
  input  logic          skip_del,
  input  logic [TW-1:0] gap_limit,
  input  logic          byte_tick,
  input  logic          index_pulse,
  input  logic          id_valid,
  input  logic [W-1:0]  id_track,
  input  logic [W-1:0]  id_head,
  input  logic [W-1:0]  id_sector,
  input  logic [W-1:0]  id_size,
  input  logic          id_crc_err,
  input  logic          dmark_valid,
  input  logic          dmark_deleted,
  input  logic          sec_done,
  input  logic          host_wr,
  output logic          busy,
  output logic          done,
  output logic          data_start,
  output logic [7:0]    st1,
  output logic [7:0]    st2,
  output logic          hd_side,
  output logic [W-1:0]  cur_sec
);
  import sss_pkg::*;

  localparam logic [W-1:0] SEC_FIRST = W'(1);

  sss_state_e    st_q, st_d;
  logic [W-1:0]  head_q, head_d, sec_q, sec_d, ltrk_q, ltrk_d;
  logic          seen_q, seen_d;
  logic [7:0]    st1_q, st1_d, st2_q, st2_d;
  logic          done_q, done_d, ds_q, ds_d;
  logic [W-1:0]  rq_trk_q, rq_sz_q, eot_q;
  logic          mt_q, sk_q;
  logic [TW-1:0] gap_q;
  logic          cmd_ld, srch_clr, tm_clr, advance, finish;
  logic          idx_exp, tm_exp, id_hit;
  logic [3:0]    fld_eq;

  sss_id_match #(.W(W), .NF(4)) u_match (
    .got  ({id_track, id_head, id_sector, id_size}),
    .want ({rq_trk_q, head_q, sec_q, rq_sz_q}),
    .eq   (fld_eq),
    .hit  (id_hit)
  );

  sss_index_watch #(.NP(NIDX)) u_index (
    .clk    (clk),
    .rst_n  (rst_n),
    .clr    (srch_clr),
    .en     (st_q == S_SEARCH),
    .pulse  (index_pulse),
    .expire (idx_exp)
  );

  sss_data_timer #(.TW(TW)) u_timer (
    .clk    (clk),
    .rst_n  (rst_n),
    .clr    (tm_clr),
    .en     (st_q == S_WAIT_DM),
    .tick   (byte_tick),
    .limit  (gap_q),
    .expire (tm_exp)
  );

  assign cmd_ld = start && (st_q == S_IDLE);

  always_comb begin
    st_d     = st_q;
    head_d   = head_q;
    sec_d    = sec_q;
    seen_d   = seen_q;
    ltrk_d   = ltrk_q;
    st1_d    = st1_q;
    st2_d    = st2_q;
    done_d   = 1'b0;
    ds_d     = 1'b0;
    srch_clr = 1'b0;
    tm_clr   = 1'b0;
    advance  = 1'b0;
    finish   = 1'b0;
    unique case (st_q)
      S_IDLE: begin
        if (start) begin
          st_d     = S_SEARCH;
          head_d   = req_head;
          sec_d    = req_sector;
          st1_d    = '0;
          st2_d    = '0;
          seen_d   = 1'b0;
          srch_clr = 1'b1;
        end
      end
      S_SEARCH: begin
        if (host_wr) begin
          finish = 1'b1;
        end else if (id_valid && id_crc_err) begin
          st1_d[ST1_CRC] = 1'b1;
          finish         = 1'b1;
        end else begin
          if (id_valid) begin
            seen_d = 1'b1;
            ltrk_d = id_track;
          end
          if (id_valid && id_hit) begin
            st_d   = S_WAIT_DM;
            tm_clr = 1'b1;
          end else if (idx_exp) begin
            finish = 1'b1;
            if (!seen_d)                st1_d[ST1_NOMARK] = 1'b1;
            else if (ltrk_d == rq_trk_q) st1_d[ST1_NODATA] = 1'b1;
            else if (ltrk_d == '1)      st2_d[ST2_BADTRK] = 1'b1;
            else                        st2_d[ST2_WRTRK]  = 1'b1;
          end
        end
      end
      S_WAIT_DM: begin
        if (host_wr) begin
          finish = 1'b1;
        end else if (dmark_valid) begin
          if (dmark_deleted && sk_q) begin
            advance = 1'b1;
          end else begin
            ds_d = 1'b1;
            st_d = S_XFER;
          end
        end else if (tm_exp) begin
          st1_d[ST1_NOMARK] = 1'b1;
          finish            = 1'b1;
        end
      end
      S_XFER: begin
        if (host_wr)       finish  = 1'b1;
        else if (sec_done) advance = 1'b1;
      end
      default: st_d = S_IDLE;
    endcase

    if (advance) begin
      if (sec_q == eot_q) begin
        if (mt_q && !head_q[0]) begin
          head_d[0] = 1'b1;
          sec_d     = SEC_FIRST;
          st_d      = S_SEARCH;
          seen_d    = 1'b0;
          srch_clr  = 1'b1;
        end else begin
          finish = 1'b1;
        end
      end else begin
        sec_d    = sec_q + SEC_FIRST;
        st_d     = S_SEARCH;
        seen_d   = 1'b0;
        srch_clr = 1'b1;
      end
    end

    if (finish) begin
      st_d   = S_IDLE;
      done_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= S_IDLE;
      head_q <= '0;
      sec_q  <= '0;
      ltrk_q <= '0;
      seen_q <= 1'b0;
      st1_q  <= '0;
      st2_q  <= '0;
      done_q <= 1'b0;
      ds_q   <= 1'b0;
    end else begin
      st_q   <= st_d;
      head_q <= head_d;
      sec_q  <= sec_d;
      ltrk_q <= ltrk_d;
      seen_q <= seen_d;
      st1_q  <= st1_d;
      st2_q  <= st2_d;
      done_q <= done_d;
      ds_q   <= ds_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rq_trk_q <= '0;
      rq_sz_q  <= '0;
      eot_q    <= '0;
      mt_q     <= 1'b0;
      sk_q     <= 1'b0;
      gap_q    <= '0;
    end else if (cmd_ld) begin
      rq_trk_q <= req_track;
      rq_sz_q  <= req_size;
      eot_q    <= eot_sector;
      mt_q     <= multi_trk;
      sk_q     <= skip_del;
      gap_q    <= gap_limit;
    end
  end

  assign busy       = (st_q != S_IDLE);
  assign done       = done_q;
  assign data_start = ds_q;
  assign st1        = st1_q;
  assign st2        = st2_q;
  assign hd_side    = head_q[0];
  assign cur_sec    = sec_q;

  // R13: done never lasts two cycles
  a_r13_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  // R2: a new command begins with clean status
  a_r2_status_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && start) |=> (busy && st1 == 8'h00 && st2 == 8'h00));
  // R9: data_start only follows a data mark
  a_r9_ds_after_mark: assert property (@(posedge clk) disable iff (!rst_n)
    data_start |-> $past(dmark_valid));
  // R7: a CRC-flagged field during a search ends the command
  a_r7_crc_ends: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == S_SEARCH && id_valid && id_crc_err && !host_wr) |=> (done && st1[ST1_CRC]));
  // R12: host write aborts at once
  a_r12_abort: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && host_wr) |=> (!busy && done));
endmodule

// File: tb/sim_sector_seek_ctl.sv
module sim_sector_seek_ctl;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 0, multi_trk = 0, skip_del = 0, byte_tick = 0, index_pulse = 0;
  logic        id_valid = 0, id_crc_err = 0, dmark_valid = 0, dmark_deleted = 0;
  logic        sec_done = 0, host_wr = 0;
  logic [7:0]  req_track = 0, req_head = 0, req_sector = 0, req_size = 0, eot_sector = 0;
  logic [7:0]  id_track = 0, id_head = 0, id_sector = 0, id_size = 0;
  logic [15:0] gap_limit = 0;
  logic        busy, done, data_start, hd_side;
  logic [7:0]  st1, st2, cur_sec;

  int checks = 0;
  int errors = 0;
  bit fin = 0;

  always #2 clk = ~clk;

  sector_seek_ctl u0 (
    .clk(clk), .rst_n(rst_n), .start(start), .req_track(req_track), .req_head(req_head),
    .req_sector(req_sector), .req_size(req_size), .eot_sector(eot_sector),
    .multi_trk(multi_trk), .skip_del(skip_del), .gap_limit(gap_limit),
    .byte_tick(byte_tick), .index_pulse(index_pulse), .id_valid(id_valid),
    .id_track(id_track), .id_head(id_head), .id_sector(id_sector), .id_size(id_size),
    .id_crc_err(id_crc_err), .dmark_valid(dmark_valid), .dmark_deleted(dmark_deleted),
    .sec_done(sec_done), .host_wr(host_wr), .busy(busy), .done(done),
    .data_start(data_start), .st1(st1), .st2(st2), .hd_side(hd_side), .cur_sec(cur_sec)
  );

  typedef struct packed {
    logic [7:0] t, h, s, z;
    logic       m;
    logic [7:0] e1, e2;
  } vec_t;

  // request is track 5, head 0, sector 3, size 2; one probe field per row
  localparam vec_t TBL [6] = '{
    '{8'd5,   8'd0, 8'd3, 8'd2, 1'b1, 8'h00, 8'h00},
    '{8'd6,   8'd0, 8'd3, 8'd2, 1'b0, 8'h00, 8'h10},
    '{8'hFF,  8'd0, 8'd3, 8'd2, 1'b0, 8'h00, 8'h02},
    '{8'd5,   8'd1, 8'd3, 8'd2, 1'b0, 8'h04, 8'h00},
    '{8'd5,   8'd0, 8'd4, 8'd2, 1'b0, 8'h04, 8'h00},
    '{8'd5,   8'd0, 8'd3, 8'd1, 1'b0, 8'h04, 8'h00}
  };

  task automatic cyc();
    @(posedge clk);
    #1;
  endtask

  task automatic chk(string r, logic [15:0] act, logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", r, act, exp);
    end
  endtask

  task automatic do_start(logic [7:0] t, logic [7:0] h, logic [7:0] s, logic [7:0] e,
                          logic mt, logic sk, logic [15:0] g);
    req_track = t; req_head = h; req_sector = s; req_size = 8'd2;
    eot_sector = e; multi_trk = mt; skip_del = sk; gap_limit = g;
    start = 1; cyc(); start = 0;
  endtask

  task automatic send_id(logic [7:0] t, logic [7:0] h, logic [7:0] s, logic [7:0] z, logic crc);
    id_track = t; id_head = h; id_sector = s; id_size = z; id_crc_err = crc;
    id_valid = 1; cyc(); id_valid = 0; id_crc_err = 0;
  endtask

  task automatic send_dm(logic del);
    dmark_deleted = del; dmark_valid = 1; cyc(); dmark_valid = 0; dmark_deleted = 0;
  endtask

  task automatic pulse_idx();
    index_pulse = 1; cyc(); index_pulse = 0;
  endtask

  task automatic pulse_tick();
    byte_tick = 1; cyc(); byte_tick = 0;
  endtask

  task automatic pulse_sd();
    sec_done = 1; cyc(); sec_done = 0;
  endtask

  task automatic abort();
    host_wr = 1; cyc(); host_wr = 0; cyc();
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!fin) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) cyc();
    // R1 reset state
    chk("R1 busy", busy, 0);
    chk("R1 done", done, 0);
    chk("R1 ds", data_start, 0);
    chk("R1 st", {st1, st2}, 16'h0000);
    rst_n = 1;
    cyc();

    // R3 R5 R6 table of probe fields
    foreach (TBL[i]) begin
      do_start(8'd5, 8'd0, 8'd3, 8'd9, 0, 0, 16'd50);
      chk("R2 busy", busy, 1);
      send_id(TBL[i].t, TBL[i].h, TBL[i].s, TBL[i].z, 0);
      if (TBL[i].m) begin
        send_dm(0);
        chk("R3 match ds", data_start, 1);
        abort();
      end else begin
        pulse_idx();
        chk("R3 still busy", busy, 1);
        pulse_idx();
        chk("R5 R6 done", done, 1);
        chk("R5 R6 status", {st1, st2}, {TBL[i].e1, TBL[i].e2});
        cyc();
        chk("R13 done low", done, 0);
      end
    end

    // R4 no field at all
    do_start(8'd5, 8'd0, 8'd3, 8'd9, 0, 0, 16'd50);
    pulse_idx(); pulse_idx();
    chk("R4 status", {done, st1, st2}, {1'b1, 8'h01, 8'h00});
    cyc();

    // R7 CRC
    do_start(8'd5, 8'd0, 8'd3, 8'd9, 0, 0, 16'd50);
    send_id(8'd5, 8'd0, 8'd3, 8'd2, 1);
    chk("R7 crc", {done, st1, st2}, {1'b1, 8'h20, 8'h00});
    cyc();

    // R8 data timeout with limit 4
    do_start(8'd5, 8'd0, 8'd3, 8'd9, 0, 0, 16'd4);
    send_id(8'd5, 8'd0, 8'd3, 8'd2, 0);
    for (int k = 0; k < 3; k++) pulse_tick();
    chk("R8 early", {busy, done}, 2'b10);
    pulse_tick();
    chk("R8 expire", {done, st1, st2}, {1'b1, 8'h01, 8'h00});
    cyc();

    // R9 deleted with skip on, then next sector
    do_start(8'd5, 8'd0, 8'd3, 8'd9, 0, 1, 16'd50);
    send_id(8'd5, 8'd0, 8'd3, 8'd2, 0);
    send_dm(1);
    chk("R9 skip no ds", {data_start, busy}, 2'b01);
    chk("R9 skip advance", cur_sec, 8'd4);
    send_id(8'd5, 8'd0, 8'd4, 8'd2, 0);
    send_dm(0);
    chk("R9 next ds", data_start, 1);
    abort();

    // R9 deleted with skip off
    do_start(8'd5, 8'd0, 8'd3, 8'd9, 0, 0, 16'd50);
    send_id(8'd5, 8'd0, 8'd3, 8'd2, 0);
    send_dm(1);
    chk("R9 noskip ds", data_start, 1);
    // R10 advance below eot
    pulse_sd();
    chk("R10 advance", {busy, cur_sec}, {1'b1, 8'd4});
    abort();

    // R10 single-track end
    do_start(8'd5, 8'd0, 8'd9, 8'd9, 0, 0, 16'd50);
    send_id(8'd5, 8'd0, 8'd9, 8'd2, 0);
    send_dm(0);
    pulse_sd();
    chk("R10 eot end", {done, st1, st2}, {1'b1, 8'h00, 8'h00});
    cyc();

    // R11 multi-track continues on side 1
    do_start(8'd5, 8'd0, 8'd9, 8'd9, 1, 0, 16'd50);
    send_id(8'd5, 8'd0, 8'd9, 8'd2, 0);
    send_dm(0);
    pulse_sd();
    chk("R11 side1", {busy, done, hd_side, cur_sec}, {3'b101, 8'd1});
    send_id(8'd5, 8'd1, 8'd1, 8'd2, 0);
    send_dm(0);
    chk("R11 side1 ds", data_start, 1);
    // R12 abort keeps status
    host_wr = 1; cyc(); host_wr = 0;
    chk("R12 abort", {busy, done, st1, st2}, {2'b01, 16'h0000});
    cyc();

    // R11 end on side 1
    do_start(8'd5, 8'd1, 8'd9, 8'd9, 1, 0, 16'd50);
    send_id(8'd5, 8'd1, 8'd9, 8'd2, 0);
    send_dm(0);
    pulse_sd();
    chk("R11 side1 end", {busy, done}, 2'b01);
    cyc();

    // R2 start while busy ignored
    do_start(8'd5, 8'd0, 8'd3, 8'd9, 0, 0, 16'd50);
    do_start(8'd5, 8'd0, 8'd7, 8'd9, 0, 0, 16'd50);
    chk("R2 keep sec", cur_sec, 8'd3);
    send_id(8'd5, 8'd0, 8'd3, 8'd2, 0);
    send_dm(0);
    chk("R2 ignored start", data_start, 1);
    abort();

    fin = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule